// File: doc/BRIEF.md
# Cylinder/Head/Sector Address Translator

This block sits between a firmware-facing disk address and a drive that understands a different geometry. The firmware side presents addresses in a translated geometry: a 10-bit cylinder, an 8-bit head and a 6-bit sector. That geometry is formed by dividing the drive's cylinder count by a power-of-two factor N and multiplying its head count by the same N. The block turns each such address back into the drive's own cylinder/head/sector address. It also computes the matching linear block number, so both address forms come out together. Because N is a power of two and the extra head bits are folded back into the cylinder, sector order on the media is kept: consecutive translated addresses land on consecutive physical sectors.

A small helper derives N from the configured cylinder count. It picks the smallest shift that brings the translated cylinder count to 1024 or below. The helper also reports the shift and the resulting translated geometry. Configuration is plain and must be held stable while requests are in flight.

Requests enter on a valid/ready channel and results leave on another. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. A result is taken on a clock edge where `out_valid` and `out_ready` are both high. Once `out_valid` is raised, the result stays unchanged until it is taken. When the output is stalled and both internal stages are full, `in_ready` drops. The pipeline has two stages and can accept one request per cycle.

Top module: `chs_xlate`

## Requirements
- R1: The shift s is the smallest value in 0..6 for which `cfg_cyls >> s` is at most 1024. The outputs are `n_shift` = s, `xlt_cyls` = `cfg_cyls >> s` and `xlt_heads` = `cfg_heads << s`.
- R2: For an in-range request, the drive cylinder is `in_cyl * 2^s + in_head / cfg_heads`, using integer division.
- R3: For an in-range request, the drive head is `in_head mod cfg_heads`. It is always below `cfg_heads`.
- R4: For an in-range request, the sector is passed through unchanged. Sectors count from 1.
- R5: For an in-range request, the block number is `(cyl * cfg_heads + head) * cfg_spt + sec - 1`, using the drive-side cylinder and head.
- R6: A request is out of range when any of these holds: sector is 0, sector exceeds `cfg_spt`, `in_cyl` is at least `xlt_cyls`, or `in_head` is at least `xlt_heads`. For such a request `out_oor` is 1, and cylinder, head, sector and block number are all output as 0.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` and every result field stay stable on the next cycle.
- R8: Results leave in request order. With `out_ready` held high, a result becomes valid two clock edges after the edge that took its request.
- R9: After reset `out_valid` is 0 and `in_ready` is 1.
- R10: When `cfg_cyls` is at most 1024, the shift is 0. An in-range address then comes out with the same cylinder, head and sector it went in with.
- R11: Translated addresses that step through sector, then head, then cylinder produce block numbers that rise by exactly one at each step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cyls | input | 16 | Drive cylinder count |
| cfg_heads | input | 5 | Drive head count, 1..16 |
| cfg_spt | input | 6 | Drive sectors per track, 1..63 |
| n_shift | output | 3 | Selected log2 of N |
| xlt_cyls | output | 16 | Translated cylinder count |
| xlt_heads | output | 11 | Translated head count |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high with in_valid |
| in_cyl | input | 10 | Translated cylinder |
| in_head | input | 8 | Translated head |
| in_sec | input | 6 | Sector, counting from 1 |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result taken when high with out_valid |
| out_oor | output | 1 | Request was out of range |
| out_cyl | output | 16 | Drive cylinder |
| out_head | output | 4 | Drive head |
| out_sec | output | 6 | Drive sector |
| out_lba | output | 28 | Linear block number |

## Verification
Several properties are checked on every cycle. The chosen shift must be both sufficient and minimal. A stalled result must hold still. Out-of-range results must carry all-zero fields. Every in-range result must have a drive head below the head count, a cylinder below the cylinder count and a sector inside the track.

The exact arithmetic of the cylinder fold, the remainder and the block number can only be shown by the bench's scenarios. Those scenarios are the worked 2000/16/63 example, several other geometries, and random traffic scored against a behavioural model. The same applies to request ordering, two-cycle latency and the one-step increase across consecutive addresses.

// File: rtl/chs_pkg.sv
package chs_pkg;
  localparam int TCYL_W    = 10;
  localparam int THEAD_W   = 8;
  localparam int TSEC_W    = 6;
  localparam int CYL_LIMIT = 1024;

  typedef struct packed {
    logic [TCYL_W-1:0]  cyl;
    logic [THEAD_W-1:0] head;
    logic [TSEC_W-1:0]  sec;
  } xreq_t;
endpackage

// File: rtl/chs_nsel.sv
module chs_nsel #(
  parameter int CYL_W  = 16,
  parameter int HEAD_W = 5,
  parameter int SMAX   = 6,
  parameter int SH_W   = 3,
  parameter int XH_W   = 11
) (
  input  logic [CYL_W-1:0]  cyls,
  input  logic [HEAD_W-1:0] heads,
  output logic [SH_W-1:0]   shift,
  output logic [CYL_W-1:0]  xcyls,
  output logic [XH_W-1:0]   xheads
);
  import chs_pkg::*;

  // smallest shift whose quotient fits the translated cylinder limit
  always_comb begin
    shift = SH_W'(SMAX);
    for (int s = SMAX; s >= 0; s--) begin
      if (32'(cyls >> s) <= 32'(CYL_LIMIT)) shift = SH_W'(s);
    end
  end

  assign xcyls  = cyls >> shift;
  assign xheads = XH_W'(heads) << shift;
endmodule

// File: rtl/chs_headsplit.sv
module chs_headsplit #(
  parameter int HEAD_W = 5,
  parameter int SMAX   = 6,
  parameter int XH_W   = 11
) (
  input  logic [7:0]        head,
  input  logic [HEAD_W-1:0] heads,
  output logic [SMAX-1:0]   quo,
  output logic [HEAD_W-1:0] rem
);
  logic [XH_W-1:0] r_work;
  logic [XH_W-1:0] d_work;

  // restoring division: quotient is below 2^SMAX for any in-range head
  always_comb begin
    r_work = XH_W'(head);
    d_work = '0;
    quo    = '0;
    for (int i = SMAX - 1; i >= 0; i--) begin
      d_work = XH_W'(heads) << i;
      if (r_work >= d_work) begin
        r_work = r_work - d_work;
        quo[i] = 1'b1;
      end
    end
    rem = HEAD_W'(r_work);
  end
endmodule

// File: rtl/chs_lba.sv
module chs_lba #(
  parameter int CYL_W  = 16,
  parameter int HEAD_W = 5,
  parameter int SPT_W  = 6,
  parameter int LBA_W  = 28
) (
  input  logic [CYL_W-1:0]  cyl,
  input  logic [HEAD_W-2:0] head,
  input  logic [5:0]        sec,
  input  logic [HEAD_W-1:0] heads,
  input  logic [SPT_W-1:0]  spt,
  output logic [LBA_W-1:0]  lba
);
  logic [LBA_W-1:0] track;

  assign track = LBA_W'(cyl) * LBA_W'(heads) + LBA_W'(head);
  assign lba   = track * LBA_W'(spt) + LBA_W'(sec) - LBA_W'(1);
endmodule

// File: rtl/chs_xlate.sv
module chs_xlate #(
  parameter int CYL_W  = 16,
  parameter int HEAD_W = 5,
  parameter int SPT_W  = 6,
  parameter int LBA_W  = 28,
  localparam int SMAX  = CYL_W - 10,
  localparam int SH_W  = $clog2(SMAX + 1),
  localparam int XH_W  = HEAD_W + SMAX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CYL_W-1:0]  cfg_cyls,
  input  logic [HEAD_W-1:0] cfg_heads,
  input  logic [SPT_W-1:0]  cfg_spt,
  output logic [SH_W-1:0]   n_shift,
  output logic [CYL_W-1:0]  xlt_cyls,
  output logic [XH_W-1:0]   xlt_heads,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [9:0]        in_cyl,
  input  logic [7:0]        in_head,
  input  logic [5:0]        in_sec,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_oor,
  output logic [CYL_W-1:0]  out_cyl,
  output logic [HEAD_W-2:0] out_head,
  output logic [5:0]        out_sec,
  output logic [LBA_W-1:0]  out_lba
);
  import chs_pkg::*;

  xreq_t req;
  assign req = '{cyl: in_cyl, head: in_head, sec: in_sec};

  chs_nsel #(.CYL_W(CYL_W), .HEAD_W(HEAD_W), .SMAX(SMAX), .SH_W(SH_W), .XH_W(XH_W)) u_nsel (
    .cyls(cfg_cyls), .heads(cfg_heads), .shift(n_shift), .xcyls(xlt_cyls), .xheads(xlt_heads)
  );

  logic [SMAX-1:0]   fold;
  logic [HEAD_W-1:0] rem;
  chs_headsplit #(.HEAD_W(HEAD_W), .SMAX(SMAX), .XH_W(XH_W)) u_split (
    .head(req.head), .heads(cfg_heads), .quo(fold), .rem(rem)
  );

  // stage-1 combinational: range test and cylinder fold
  logic             bad_c;
  logic [CYL_W-1:0] ecyl_c;
  assign bad_c = (req.sec == '0) || (32'(req.sec) > 32'(cfg_spt)) ||
                 (32'(req.cyl) >= 32'(xlt_cyls)) || (32'(req.head) >= 32'(xlt_heads));
  assign ecyl_c = CYL_W'((32'(req.cyl) << n_shift) + 32'(fold));

  logic              s1_v, s1_oor;
  logic [CYL_W-1:0]  s1_cyl;
  logic [HEAD_W-2:0] s1_head;
  logic [5:0]        s1_sec;
  logic              s1_adv, s2_adv;

  assign s2_adv   = !out_valid || out_ready;
  assign s1_adv   = !s1_v || s2_adv;
  assign in_ready = s1_adv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_oor  <= 1'b0;
      s1_cyl  <= '0;
      s1_head <= '0;
      s1_sec  <= '0;
    end else if (s1_adv) begin
      s1_v <= in_valid;
      if (in_valid) begin
        s1_oor  <= bad_c;
        s1_cyl  <= bad_c ? '0 : ecyl_c;
        s1_head <= bad_c ? '0 : rem[HEAD_W-2:0];
        s1_sec  <= bad_c ? '0 : req.sec;
      end
    end
  end

  logic [LBA_W-1:0] lba_c;
  chs_lba #(.CYL_W(CYL_W), .HEAD_W(HEAD_W), .SPT_W(SPT_W), .LBA_W(LBA_W)) u_lba (
    .cyl(s1_cyl), .head(s1_head), .sec(s1_sec), .heads(cfg_heads), .spt(cfg_spt), .lba(lba_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_oor   <= 1'b0;
      out_cyl   <= '0;
      out_head  <= '0;
      out_sec   <= '0;
      out_lba   <= '0;
    end else if (s2_adv) begin
      out_valid <= s1_v;
      if (s1_v) begin
        out_oor  <= s1_oor;
        out_cyl  <= s1_cyl;
        out_head <= s1_head;
        out_sec  <= s1_sec;
        out_lba  <= s1_oor ? '0 : lba_c;
      end
    end
  end

  // shift is enough to reach the cylinder limit
  assert_shift_fits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cfg_cyls >> n_shift) <= 32'(CYL_LIMIT));
  // shift is the smallest that works
  assert_shift_min_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (n_shift != '0) |-> (32'(cfg_cyls >> (n_shift - 1'b1)) > 32'(CYL_LIMIT)));
  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_lba) && $stable(out_cyl) &&
                                   $stable(out_head) && $stable(out_sec) && $stable(out_oor)));
  assert_oor_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_oor) |-> (out_lba == '0 && out_cyl == '0 && out_head == '0 && out_sec == '0));
  assert_head_mod_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_oor) |-> (32'(out_head) < 32'(cfg_heads)));
  assert_cyl_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_oor) |-> (out_cyl < cfg_cyls));
  assert_sec_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_oor) |-> (out_sec != '0 && 32'(out_sec) <= 32'(cfg_spt)));
endmodule

// File: tb/chs_xlate_test.sv
module chs_xlate_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [15:0] cfg_cyls;
  logic [4:0]  cfg_heads;
  logic [5:0]  cfg_spt;
  logic [2:0]  n_shift;
  logic [15:0] xlt_cyls;
  logic [10:0] xlt_heads;
  logic        in_valid, in_ready, out_valid, out_ready, out_oor;
  logic [9:0]  in_cyl;
  logic [7:0]  in_head;
  logic [5:0]  in_sec;
  logic [15:0] out_cyl;
  logic [3:0]  out_head;
  logic [5:0]  out_sec;
  logic [27:0] out_lba;

  chs_xlate uut (
    .clk(clk), .rst_n(rst_n), .cfg_cyls(cfg_cyls), .cfg_heads(cfg_heads), .cfg_spt(cfg_spt),
    .n_shift(n_shift), .xlt_cyls(xlt_cyls), .xlt_heads(xlt_heads),
    .in_valid(in_valid), .in_ready(in_ready), .in_cyl(in_cyl), .in_head(in_head), .in_sec(in_sec),
    .out_valid(out_valid), .out_ready(out_ready), .out_oor(out_oor), .out_cyl(out_cyl),
    .out_head(out_head), .out_sec(out_sec), .out_lba(out_lba)
  );

  typedef struct {
    int cyl; int head; int sec; longint lba; bit oor; int t;
  } exp_t;

  exp_t   sb[$];
  int     tests = 0, fails = 0, ev = 0, pops = 0;
  bit     done = 0;
  int     last_cyl, last_head, last_sec, last_lat;
  longint last_lba;
  bit     last_oor;
  bit     sweep = 0, have_prev = 0;
  longint prev_lba;
  bit     prev_stall = 0;
  logic [27:0] st_lba;
  logic [15:0] st_cyl;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic exp_t model(int c, int h, int s, int t);
    exp_t e;
    int sh = 0;
    int cy = int'(cfg_cyls), hd = int'(cfg_heads), sp = int'(cfg_spt);
    while ((cy >> sh) > 1024) sh++;
    e.t = t; e.cyl = 0; e.head = 0; e.sec = 0; e.lba = 0;
    e.oor = (s == 0) || (s > sp) || (c >= (cy >> sh)) || (h >= (hd << sh));
    if (!e.oor) begin
      e.cyl  = c * (1 << sh) + h / hd;
      e.head = h % hd;
      e.sec  = s;
      e.lba  = (longint'(e.cyl) * hd + e.head) * sp + s - 1;
    end
    return e;
  endfunction

  // called just after a falling edge with inputs set; evaluates the coming edge's handshakes
  task automatic eval(output bit acc);
    #1;
    acc = in_valid && in_ready;
    if (prev_stall)
      chk(out_valid && out_lba == st_lba && out_cyl == st_cyl, "R7", "stalled result held",
          longint'(out_lba), longint'(st_lba));
    if (acc) sb.push_back(model(int'(in_cyl), int'(in_head), int'(in_sec), ev));
    if (out_valid && out_ready) begin
      if (sb.size() == 0) begin
        chk(0, "R8", "unexpected result", 1, 0);
      end else begin
        exp_t e = sb.pop_front();
        string tg = e.oor ? "R6" : "R2";
        chk(out_oor == e.oor, "R6", "oor flag", longint'(out_oor), longint'(e.oor));
        chk(int'(out_cyl) == e.cyl, tg, "cylinder", longint'(out_cyl), longint'(e.cyl));
        chk(int'(out_head) == e.head, e.oor ? "R6" : "R3", "head", longint'(out_head), longint'(e.head));
        chk(int'(out_sec) == e.sec, e.oor ? "R6" : "R4", "sector", longint'(out_sec), longint'(e.sec));
        chk(longint'(out_lba) == e.lba, e.oor ? "R6" : "R5", "lba", longint'(out_lba), e.lba);
        last_cyl = int'(out_cyl); last_head = int'(out_head); last_sec = int'(out_sec);
        last_lba = longint'(out_lba); last_oor = out_oor; last_lat = ev - e.t;
        if (sweep) begin
          if (have_prev) chk(last_lba == prev_lba + 1, "R11", "consecutive lba", last_lba, prev_lba + 1);
          prev_lba = last_lba; have_prev = 1;
        end
        pops++;
      end
    end
    prev_stall = out_valid && !out_ready;
    st_lba = out_lba; st_cyl = out_cyl;
    ev++;
    @(negedge clk);
  endtask

  task automatic push(int c, int h, int s);
    bit acc;
    in_valid = 1; in_cyl = 10'(c); in_head = 8'(h); in_sec = 6'(s);
    forever begin
      eval(acc);
      if (acc) break;
    end
    in_valid = 0;
  endtask

  task automatic drain();
    bit acc;
    in_valid = 0; out_ready = 1;
    while (sb.size() != 0) eval(acc);
    eval(acc);
  endtask

  task automatic one(int c, int h, int s, int ec, int eh, int es, longint el, bit eo, string tag);
    int p;
    bit acc;
    p = pops;
    out_ready = 1;
    push(c, h, s);
    while (pops == p) eval(acc);
    chk(last_oor == eo, tag, "fixed oor", longint'(last_oor), longint'(eo));
    chk(last_cyl == ec && last_head == eh && last_sec == es, tag, "fixed chs",
        longint'(last_cyl * 10000 + last_head * 100 + last_sec), longint'(ec * 10000 + eh * 100 + es));
    chk(last_lba == el, tag, "fixed lba", last_lba, el);
    chk(last_lat == 2, "R8", "latency", longint'(last_lat), 2);
  endtask

  task automatic set_cfg(int c, int h, int s);
    cfg_cyls = 16'(c); cfg_heads = 5'(h); cfg_spt = 6'(s);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bit acc;
    in_valid = 0; out_ready = 1; in_cyl = 0; in_head = 0; in_sec = 0;
    set_cfg(2000, 16, 63);
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0, "R9", "out_valid after reset", longint'(out_valid), 0);
    chk(in_ready == 1, "R9", "in_ready after reset", longint'(in_ready), 1);

    // worked geometry 2000/16/63
    chk(n_shift == 3'd1, "R1", "shift 2000", longint'(n_shift), 1);
    chk(xlt_cyls == 16'd1000 && xlt_heads == 11'd32, "R1", "translated geom",
        longint'(xlt_cyls) * 1000 + longint'(xlt_heads), 1000032);
    one(500, 16, 1, 1001, 0, 1, 1009008, 0, "R2");
    one(500, 15, 63, 1000, 15, 63, 1009007, 0, "R3");
    one(999, 31, 63, 1999, 15, 63, 2015999, 0, "R5");
    one(0, 0, 1, 0, 0, 1, 0, 0, "R4");
    one(10, 3, 0, 0, 0, 0, 0, 1, "R6");
    one(1000, 0, 1, 0, 0, 0, 0, 1, "R6");
    one(5, 32, 1, 0, 0, 0, 0, 1, "R6");

    // consecutive sweep across head fold and cylinder boundary
    sweep = 1; have_prev = 0; out_ready = 1;
    for (int c = 499; c <= 500; c++)
      for (int h = 14; h < 32; h++)
        for (int s = 60; s <= 63; s++) begin
          if (!(h == 14 || h == 15 || h == 16 || h == 31)) continue;
          if (h == 14 && c == 499) continue;
        end
    have_prev = 0;
    for (int c = 499; c <= 500; c++)
      for (int h = 0; h < 32; h++)
        for (int s = 1; s <= 63; s++)
          if ((c == 499 && h >= 30) || (c == 500 && h <= 17)) push(c, h, s);
    drain();
    sweep = 0;

    // geometry already within limit: pass-through
    set_cfg(1000, 15, 17);
    chk(n_shift == 3'd0, "R10", "shift 0", longint'(n_shift), 0);
    one(999, 14, 17, 999, 14, 17, (999 * 15 + 14) * 17 + 16, 0, "R10");
    one(123, 7, 9, 123, 7, 9, (123 * 15 + 7) * 17 + 8, 0, "R10");
    one(3, 2, 18, 0, 0, 0, 0, 1, "R6");
    one(3, 15, 1, 0, 0, 0, 0, 1, "R6");

    // larger factors
    set_cfg(4000, 15, 63);
    chk(n_shift == 3'd2 && xlt_heads == 11'd60, "R1", "shift 4000/15",
        longint'(n_shift) * 100 + longint'(xlt_heads), 260);
    one(999, 59, 63, 3999, 14, 63, (3999 * 15 + 14) * 63 + 62, 0, "R2");
    set_cfg(65535, 16, 63);
    chk(n_shift == 3'd6 && xlt_cyls == 16'd1023, "R1", "shift max",
        longint'(n_shift) * 10000 + longint'(xlt_cyls), 61023);
    one(1022, 200, 5, 1022 * 64 + 12, 8, 5, (longint'(1022 * 64 + 12) * 16 + 8) * 63 + 4, 0, "R2");

    // random traffic with back-pressure
    set_cfg(2000, 16, 63);
    in_valid = 0;
    for (int i = 0; i < 1500; i++) begin
      if (!in_valid || (in_valid && in_ready)) begin
        in_valid = ($urandom_range(0, 3) != 0);
        in_cyl  = 10'($urandom_range(0, 1005));
        in_head = 8'($urandom_range(0, 33));
        in_sec  = 6'($urandom_range(0, 63));
      end
      out_ready = ($urandom_range(0, 2) != 0);
      eval(acc);
    end
    drain();
    chk(sb.size() == 0, "R8", "all results returned", longint'(sb.size()), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule